// File: doc/BRIEF.md
# Processor Clock Throttling Controller

This block drives an active-low stop-clock line that gates the processor clock in repeating windows to lower average power and heat. A free-running counter splits time into fixed throttle periods of 2^PERIOD_LOG2 clocks. There are two sources of throttling. The first is a manual mode, which software enables with a duty field. The second is a thermal override, which takes effect once an active-high thermal alarm has stayed asserted for a qualified number of slow ticks. The override has its own duty field and wins over the manual mode.

Idle-level read requests put the processor into C2, C3 or C4. The processor stays in that level, with stop-clock held asserted, until a break event arrives. While the processor is idle, no throttling takes place. A sleep-enable input switches off both throttling sources. The block also reports the C-state that the processor currently appears to be in, including the C1 halt state and the way a stop-clock assertion makes the processor appear to be in C2.

Top module: `cpu_thr_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, stop_clk_n is 1 and cstate is 0 (C0).
- R2: With manual throttling active and duty field value n, stop_clk_n is low for n×(PERIOD/8) consecutive clocks at the start of every PERIOD-clock window, and high for the rest of the window. A value of 0 gives no assertion.
- R3: Manual throttling runs only while sw_en is 1. With sw_en at 0 and no override, stop_clk_n stays high whatever the value of sw_duty.
- R4: The thermal override becomes active only after therm_alarm has been high for QUAL_TICKS tick pulses in a row. Any cycle with therm_alarm low restarts the count.
- R5: While the override is active, throttling uses therm_duty regardless of sw_en, and it takes priority over sw_duty.
- R6: The override ends in the cycle after therm_alarm goes low. Throttling then falls back to manual mode, or to none.
- R7: A pulse on lvl_rd_valid with lvl_rd_code 1, 2 or 3 moves the processor to C2, C3 or C4 respectively, with stop_clk_n held low, until brk_evt is pulsed. Code 0 is ignored, and so is a read while the processor is already idle.
- R8: While the processor is idle, no throttle window runs. After a break event, throttle windows restart only at the next period boundary, so the first assertion can slip by up to one period.
- R9: While sleep_en is 1, neither manual nor thermal throttling asserts stop_clk_n.
- R10: Outside C2 to C4, cstate is 2 while throttling holds stop_clk_n low. Otherwise it is 1 when cpu_halt is 1, and 0 when cpu_halt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle slow time tick used to qualify the thermal alarm |
| sw_en | input | 1 | Manual throttling enable |
| sw_duty | input | 3 | Manual duty: eighths of a period with stop-clock asserted |
| therm_duty | input | 3 | Thermal override duty in eighths of a period |
| therm_alarm | input | 1 | Thermal alarm, active high |
| lvl_rd_valid | input | 1 | Idle-level read strobe |
| lvl_rd_code | input | 2 | Level read code: 1=C2, 2=C3, 3=C4, 0=none |
| brk_evt | input | 1 | Break event that ends C2 to C4 |
| sleep_en | input | 1 | Sleep entry; suppresses all throttling |
| cpu_halt | input | 1 | Processor halted (C1) |
| stop_clk_n | output | 1 | Active-low stop-clock |
| cstate | output | 3 | Current C-state number, 0 to 4 |

## Verification
The bench targets the thermal qualification filter with alarm pulses that fall one tick short of the limit. A filter that failed to restart its count would raise the override too early, and the stop windows would then show the wrong duty. It switches sw_duty while the override is active, to catch a priority mux that is wired the wrong way round. It also issues a break event in the middle of a period, to catch a design that resumes throttling partway through a window rather than at the next period boundary. Finally, it sends level reads with code 0 and reads issued while the processor is already idle. A design that accepted either of these would report the wrong cstate or leave idle at the wrong time.

// File: rtl/cpu_thr_pkg.sv
package cpu_thr_pkg;

    typedef struct packed {
        logic       idle;
        logic [1:0] lvl;
    } idle_st_t;

    localparam int unsigned DUTY_W = 3;

endpackage

// File: rtl/thr_thermal_qual.sv
module thr_thermal_qual #(
    parameter int unsigned QUAL_TICKS = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic alarm,
    output logic ovr
);
    localparam int unsigned QW = $clog2(QUAL_TICKS + 1);
    localparam logic [QW-1:0] LAST = QW'(QUAL_TICKS - 1);

    typedef struct packed {
        logic [QW-1:0] cnt;
        logic          ovr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!alarm) begin
            st_d.cnt = '0;
            st_d.ovr = 1'b0;
        end else if (tick && !st_q.ovr) begin
            if (st_q.cnt == LAST) st_d.ovr = 1'b1;
            else                  st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovr = st_q.ovr;
endmodule

// File: rtl/thr_duty_gen.sv
module thr_duty_gen #(
    parameter int unsigned PERIOD_LOG2 = 10,
    parameter int unsigned DUTY_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_on,
    input  logic [DUTY_W-1:0] duty,
    output logic              stop
);
    localparam int unsigned STEP_LOG2 = PERIOD_LOG2 - DUTY_W;

    typedef struct packed {
        logic [PERIOD_LOG2-1:0] cnt;
        logic                   arm;
        logic                   stop;
    } st_t;

    st_t st_d, st_q;
    logic [PERIOD_LOG2-1:0] thresh;
    logic                   go;

    always_comb begin
        thresh    = {duty, {STEP_LOG2{1'b0}}};
        go        = src_on && (st_q.arm || (st_q.cnt == '0));
        st_d      = st_q;
        st_d.cnt  = st_q.cnt + 1'b1;
        st_d.arm  = go;
        st_d.stop = go && (st_q.cnt < thresh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stop = st_q.stop;
endmodule

// File: rtl/thr_idle_ctl.sv
module thr_idle_ctl
    import cpu_thr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_valid,
    input  logic [1:0] rd_code,
    input  logic       brk,
    output logic       idle,
    output logic [1:0] lvl
);
    idle_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.idle) begin
            if (brk) st_d.idle = 1'b0;
        end else if (rd_valid && (rd_code != 2'd0)) begin
            st_d.idle = 1'b1;
            st_d.lvl  = rd_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle = st_q.idle;
    assign lvl  = st_q.lvl;
endmodule

// File: rtl/cpu_thr_ctrl.sv
module cpu_thr_ctrl
    import cpu_thr_pkg::*;
#(
    parameter int unsigned PERIOD_LOG2 = 10,
    parameter int unsigned QUAL_TICKS  = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              sw_en,
    input  logic [DUTY_W-1:0] sw_duty,
    input  logic [DUTY_W-1:0] therm_duty,
    input  logic              therm_alarm,
    input  logic              lvl_rd_valid,
    input  logic [1:0]        lvl_rd_code,
    input  logic              brk_evt,
    input  logic              sleep_en,
    input  logic              cpu_halt,
    output logic              stop_clk_n,
    output logic [2:0]        cstate
);
    logic              ovr_w;
    logic              idle_w;
    logic [1:0]        lvl_w;
    logic              thr_stop_w;
    logic              src_on;
    logic [DUTY_W-1:0] duty_sel;

    thr_thermal_qual #(.QUAL_TICKS(QUAL_TICKS)) qual_i (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .alarm(therm_alarm),
        .ovr  (ovr_w)
    );

    thr_idle_ctl idle_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_valid(lvl_rd_valid),
        .rd_code (lvl_rd_code),
        .brk     (brk_evt),
        .idle    (idle_w),
        .lvl     (lvl_w)
    );

    always_comb begin
        src_on   = !idle_w && !sleep_en && (ovr_w || sw_en);
        duty_sel = ovr_w ? therm_duty : sw_duty;
    end

    thr_duty_gen #(.PERIOD_LOG2(PERIOD_LOG2), .DUTY_W(DUTY_W)) duty_i (
        .clk   (clk),
        .rst_n (rst_n),
        .src_on(src_on),
        .duty  (duty_sel),
        .stop  (thr_stop_w)
    );

    always_comb begin
        stop_clk_n = !(thr_stop_w || idle_w);
        if (idle_w)          cstate = 3'({1'b0, lvl_w}) + 3'd1;
        else if (thr_stop_w) cstate = 3'd2;
        else if (cpu_halt)   cstate = 3'd1;
        else                 cstate = 3'd0;
    end
endmodule

// File: rtl/cpu_thr_ctrl_chk.sv
module cpu_thr_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_en,
    input logic       brk_evt,
    input logic       therm_alarm,
    input logic       stop_clk_n,
    input logic [2:0] cstate,
    input logic       idle,
    input logic [1:0] lvl,
    input logic       ovr
);
    AST_DEEP_IDLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate == 3'd3 || cstate == 3'd4) |-> !stop_clk_n); // R7

    AST_BREAK_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(idle) && $past(brk_evt)) |-> !idle); // R7

    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && $past(idle)) |-> $stable(lvl)); // R7

    AST_OVR_NEEDS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> $past(therm_alarm)); // R6

    AST_SLEEP_NO_THROTTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sleep_en) || $past(idle)) && !idle) |-> stop_clk_n); // R9
endmodule

bind cpu_thr_ctrl cpu_thr_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_en   (sleep_en),
    .brk_evt    (brk_evt),
    .therm_alarm(therm_alarm),
    .stop_clk_n (stop_clk_n),
    .cstate     (cstate),
    .idle       (idle_w),
    .lvl        (lvl_w),
    .ovr        (ovr_w)
);

// File: tb/cpu_thr_ctrl_tb_top.sv
module cpu_thr_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PL         = 5;
    localparam int PERIOD     = 1 << PL;
    localparam int STEP       = PERIOD / 8;
    localparam int QT         = 3;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       sw_en = 1'b0;
    logic [2:0] sw_duty = 3'd0;
    logic [2:0] therm_duty = 3'd0;
    logic       therm_alarm = 1'b0;
    logic       lvl_rd_valid = 1'b0;
    logic [1:0] lvl_rd_code = 2'd0;
    logic       brk_evt = 1'b0;
    logic       sleep_en = 1'b0;
    logic       cpu_halt = 1'b0;
    logic       stop_clk_n;
    logic [2:0] cstate;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_cnt = 0, m_arm = 0, m_stop = 0, m_q = 0, m_ovr = 0, m_idle = 0, m_lvl = 0;
    int stop_runs = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_thr_ctrl #(.PERIOD_LOG2(PL), .QUAL_TICKS(QT)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sw_en(sw_en), .sw_duty(sw_duty),
        .therm_duty(therm_duty), .therm_alarm(therm_alarm), .lvl_rd_valid(lvl_rd_valid),
        .lvl_rd_code(lvl_rd_code), .brk_evt(brk_evt), .sleep_en(sleep_en),
        .cpu_halt(cpu_halt), .stop_clk_n(stop_clk_n), .cstate(cstate)
    );

    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % TICK_DIV;
        tick <= (tdiv == 0);
    end

    always @(posedge clk) begin
        int src, duty, go, n_stop, exp_n, exp_c;
        if (!rst_n) begin
            m_cnt = 0; m_arm = 0; m_stop = 0; m_q = 0; m_ovr = 0; m_idle = 0; m_lvl = 0;
        end else begin
            src    = (!m_idle && !sleep_en && (m_ovr != 0 || sw_en)) ? 1 : 0;
            duty   = (m_ovr != 0) ? int'(therm_duty) : int'(sw_duty);
            go     = (src != 0 && (m_arm != 0 || m_cnt == 0)) ? 1 : 0;
            n_stop = (go != 0 && m_cnt < duty * STEP) ? 1 : 0;
            m_arm  = go;
            m_stop = n_stop;
            m_cnt  = (m_cnt + 1) % PERIOD;
            if (!therm_alarm) begin
                m_q = 0; m_ovr = 0;
            end else if (tick && m_ovr == 0) begin
                if (m_q == QT - 1) m_ovr = 1;
                else               m_q++;
            end
            if (m_idle != 0) begin
                if (brk_evt) m_idle = 0;
            end else if (lvl_rd_valid && lvl_rd_code != 0) begin
                m_idle = 1; m_lvl = int'(lvl_rd_code);
            end
        end
        #(CLK_PERIOD/4);
        exp_n = (m_stop != 0 || m_idle != 0) ? 0 : 1;
        if (m_idle != 0)      exp_c = m_lvl + 1;
        else if (m_stop != 0) exp_c = 2;
        else if (cpu_halt)    exp_c = 1;
        else                  exp_c = 0;
        if (!stop_clk_n) stop_runs++;
        checks++;
        if (int'(stop_clk_n) != exp_n || int'(cstate) != exp_c) begin
            failures++;
            $display("FAIL %s t=%0t stop_clk_n=%0d cstate=%0d expected stop_clk_n=%0d cstate=%0d",
                     cur_req, $time, stop_clk_n, cstate, exp_n, exp_c);
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_read(input logic [1:0] code);
        lvl_rd_code = code; lvl_rd_valid = 1'b1;
        run(1);
        lvl_rd_valid = 1'b0; lvl_rd_code = 2'd0;
    endtask

    task automatic direct(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        cur_req = "R1";
        run(3);
        direct("R1", int'(stop_clk_n), 1);
        direct("R1", int'(cstate), 0);
        rst_n = 1'b1;
        run(5);
        direct("R1", int'(stop_clk_n), 1);

        // R2: manual duty patterns
        cur_req = "R2"; sw_en = 1'b1; sw_duty = 3'd3;
        stop_runs = 0; run(3 * PERIOD);
        direct("R2", stop_runs > 0 ? 1 : 0, 1);
        sw_duty = 3'd0; run(2 * PERIOD);
        sw_duty = 3'd7; run(2 * PERIOD);
        sw_duty = 3'd1; run(2 * PERIOD);

        // R3: disabled manual mode
        cur_req = "R3"; sw_en = 1'b0; sw_duty = 3'd5;
        run(PERIOD);
        stop_runs = 0; run(2 * PERIOD);
        direct("R3", stop_runs, 0);

        // R4: alarm dropping one tick short of qualification
        cur_req = "R4"; therm_duty = 3'd6;
        therm_alarm = 1'b1; run((QT - 1) * TICK_DIV);
        therm_alarm = 1'b0; run(2);
        therm_alarm = 1'b1; run((QT - 1) * TICK_DIV);
        therm_alarm = 1'b0; run(2);
        therm_alarm = 1'b1; run((QT + 1) * TICK_DIV);

        // R5: override priority and independence from sw_en
        cur_req = "R5"; run(2 * PERIOD);
        sw_en = 1'b1; sw_duty = 3'd2; run(2 * PERIOD);

        // R7: idle levels, ignored reads
        cur_req = "R7"; run(PERIOD / 2);
        pulse_read(2'd2); run(PERIOD);
        direct("R7", int'(cstate), 3);
        pulse_read(2'd3); run(5);
        direct("R7", int'(cstate), 3);
        // R8: break mid-period, resume at boundary
        cur_req = "R8"; run(PERIOD / 3);
        brk_evt = 1'b1; run(1); brk_evt = 1'b0;
        run(2 * PERIOD);
        cur_req = "R7"; pulse_read(2'd0); run(PERIOD);
        pulse_read(2'd3); run(10);
        direct("R7", int'(cstate), 4);
        pulse_read(2'd1); brk_evt = 1'b1; run(1); brk_evt = 1'b0;
        run(PERIOD);
        pulse_read(2'd1); run(7);
        direct("R7", int'(cstate), 2);
        brk_evt = 1'b1; run(1); brk_evt = 1'b0; run(PERIOD);

        // R9: sleep suppresses both sources
        cur_req = "R9"; sleep_en = 1'b1; run(2);
        stop_runs = 0; run(2 * PERIOD);
        direct("R9", stop_runs, 0);
        sleep_en = 1'b0; run(2 * PERIOD);

        // R6: override ends, fallback to manual duty 2
        cur_req = "R6"; therm_alarm = 1'b0; run(3 * PERIOD);
        sw_en = 1'b0; run(PERIOD);

        // R10: halt reporting with and without throttling
        cur_req = "R10"; cpu_halt = 1'b1; run(PERIOD);
        direct("R10", int'(cstate), 1);
        sw_en = 1'b1; sw_duty = 3'd4; run(3 * PERIOD);
        cpu_halt = 1'b0; sw_en = 1'b0; run(2 * PERIOD);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog %s actual=running expected=finished", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule